// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Sequencer

This block lets a processor read a serial flash device as if it were memory. A read request on a simple bus port names a byte address. If the 8-byte block holding that address is already buffered, the byte comes back on the next cycle. Otherwise the block drives chip select low and sends a short programmable header. It then clocks in a burst of eight bytes into a local buffer and answers the request from that buffer.

The header can hold up to six bytes, each with its own enable. They are the command byte, the optional command byte, and four option bytes. Software may ask for chip select to stay asserted after a burst. A later read of the next 8-byte block then streams eight more bytes straight away, with no new header. Two write-only action bits let software drop chip select at once or flush the buffer. The serial link runs in clock mode 0 with SCK at half the system clock, on one data lane in each direction. There is no address phase and there are no dummy cycles. Register writes that carry action bits are expected only while no read is outstanding.

Top module: `flash_read_seq`

## Requirements
- R1: After reset csN is high, sck is low, mosi is low and respValid is low.
- R2: On a fresh access the enabled header bytes go out MSB first, in this fixed order, with disabled bytes skipped:
  - command: register 1 bits 23:16, enabled by register 3 bit 14;
  - optional command: register 1 bits 7:0, enabled by register 3 bit 12;
  - option byte 3: register 2 bits 31:24, enabled by register 3 bit 7;
  - option byte 2: register 2 bits 23:16, enabled by bit 6;
  - option byte 1: register 2 bits 15:8, enabled by bit 5;
  - option byte 0: register 2 bits 7:0, enabled by bit 4.
- R3: The burst-enable bit is control register (address 0) bit 8. With it set, a read that misses clocks in eight bytes after the header. Burst byte k is stored at block offset k, and the response is the byte at the requested offset. The serial timing is mode 0: sck idles low, mosi changes on the falling edge, and miso is sampled on the rising edge. mosi is low for the whole data phase.
- R4: With burst enable set, a read of the valid buffered block returns its byte with respValid one cycle after the request. It causes no chip-select activity.
- R5: Writing control bit 9 as 1 invalidates the buffer. The next read starts a new chip-select assertion and header.
- R6: With burst enable and control bit 0 (hold) set, csN stays low after a burst. A read of the next block (block index plus one) then clocks in eight more bytes with no new header and no csN rise.
- R7: A miss to any other block while chip select is held raises csN for exactly one cycle. It then sends a fresh header.
- R8: Writing control bit 24 as 1 while idle raises csN on the next cycle. The next read is a fresh access.
- R9: With burst enable clear, every read is a fresh access of one data byte, and csN rises after it even when hold is set.
- R10: sck is high only while csN is low, and never for two cycles in a row.
- R11: respValid is a single-cycle pulse for each request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select: 0 control, 1 command, 2 option bytes, 3 enables |
| regWrData | input | 32 | Register write data |
| reqValid | input | 1 | Read request, one cycle, only while idle |
| reqAddr | input | ADDR_W | Byte address of the read |
| respValid | output | 1 | Read data valid pulse |
| respData | output | 8 | Read data byte |
| sck | output | 1 | Serial clock |
| csN | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data to flash |
| miso | input | 1 | Serial data from flash |

## Verification
The bound checker watches the serial pins on every cycle. It checks that sck only pulses while chip select is low and never stays high for two cycles, and that mosi is quiet while chip select is high. It also checks that each response is a single pulse and that the chip-select release action takes effect on the next cycle. Header order, the per-byte enables, the buffer hit and miss decisions, flush, held-select continuation with its one-cycle release gap, and single-byte mode can only be shown by the bench. It does this with a behavioural flash model that records the header and serves a position-dependent data stream. The bench sweeps all 64 header-enable patterns.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;
  localparam int HDR_SLOTS  = 6;
  localparam int SLOT_W     = 3;
  localparam int BURST_LOG2 = 3;
  localparam int BURST_BYTES = 1 << BURST_LOG2;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_CMD  = 2'd1;
  localparam logic [1:0] REG_OPT  = 2'd2;
  localparam logic [1:0] REG_EN   = 2'd3;

  typedef enum logic [2:0] {
    S_IDLE, S_GAP, S_HDR, S_DATA, S_RESP
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic                  load;      // start a serial byte
    logic                  loadData;  // byte is a data byte (mosi held low)
    logic [SLOT_W-1:0]     hdrSel;    // header slot to transmit
    logic                  capture;   // store received byte
    logic [BURST_LOG2-1:0] bufIdx;    // buffer slot for the stored byte
    logic [BURST_LOG2-1:0] rdIdx;     // buffer slot for the response
  } seqStrobe_t;
endpackage

// File: rtl/flash_rd_datapath.sv
module flash_rd_datapath
  import flash_rd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [1:0]           regAddr,
  input  logic [31:0]          regWrData,
  input  logic                 miso,
  input  seqStrobe_t           stb,
  output logic                 sck,
  output logic                 mosi,
  output logic                 byteDone,
  output logic [HDR_SLOTS-1:0] hdrEn,
  output logic                 burstEn,
  output logic                 holdEn,
  output logic                 flushReq,
  output logic                 csOffReq,
  output logic [7:0]           respData
);
  logic [7:0]  cmdByte, optCmdByte;
  logic [31:0] optBytes;
  logic [HDR_SLOTS-1:0] enBits;

  logic        engBusy, engPhase;
  logic [2:0]  bitIdx;
  logic [7:0]  txSh, rxSh;
  logic [7:0]  hdrByte;
  logic [7:0]  burstBuf [BURST_BYTES];

  logic ctrlWr;
  assign ctrlWr   = regWrEn && (regAddr == REG_CTRL);
  assign flushReq = ctrlWr && regWrData[9];
  assign csOffReq = ctrlWr && regWrData[24];

  // bits of the write word this block does not decode
  logic unusedWrBits;
  assign unusedWrBits = ^{regWrData[31:25], regWrData[15], regWrData[13],
                          regWrData[11:10], regWrData[3:1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdByte    <= '0;
      optCmdByte <= '0;
      optBytes   <= '0;
      enBits     <= '0;
      burstEn    <= 1'b0;
      holdEn     <= 1'b0;
    end else if (regWrEn) begin
      unique case (regAddr)
        REG_CTRL: begin
          burstEn <= regWrData[8];
          holdEn  <= regWrData[0];
        end
        REG_CMD: begin
          cmdByte    <= regWrData[23:16];
          optCmdByte <= regWrData[7:0];
        end
        REG_OPT: optBytes <= regWrData;
        REG_EN:  enBits   <= {regWrData[4], regWrData[5], regWrData[6],
                              regWrData[7], regWrData[12], regWrData[14]};
        default: ;
      endcase
    end
  end

  assign hdrEn = enBits;

  // slot order: command, optional command, option 3 .. option 0
  always_comb begin
    unique case (stb.hdrSel)
      3'd0:    hdrByte = cmdByte;
      3'd1:    hdrByte = optCmdByte;
      3'd2:    hdrByte = optBytes[31:24];
      3'd3:    hdrByte = optBytes[23:16];
      3'd4:    hdrByte = optBytes[15:8];
      3'd5:    hdrByte = optBytes[7:0];
      default: hdrByte = 8'h00;
    endcase
  end

  // serial byte engine: two clocks per bit, sck low then high
  assign byteDone = engBusy && engPhase && (bitIdx == 3'd7);
  assign sck      = engBusy && engPhase;
  assign mosi     = engBusy && txSh[7];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      engBusy  <= 1'b0;
      engPhase <= 1'b0;
      bitIdx   <= '0;
      txSh     <= '0;
      rxSh     <= '0;
    end else begin
      if (engBusy && engPhase) begin
        rxSh     <= {rxSh[6:0], miso};
        txSh     <= {txSh[6:0], 1'b0};
        engPhase <= 1'b0;
        bitIdx   <= bitIdx + 3'd1;
      end else if (engBusy) begin
        engPhase <= 1'b1;
      end
      if (byteDone) engBusy <= 1'b0;
      if (stb.load) begin
        engBusy  <= 1'b1;
        engPhase <= 1'b0;
        bitIdx   <= '0;
        txSh     <= stb.loadData ? 8'h00 : hdrByte;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < BURST_BYTES; i++) burstBuf[i] <= '0;
    end else if (stb.capture) begin
      burstBuf[stb.bufIdx] <= {rxSh[6:0], miso};
    end
  end

  assign respData = burstBuf[stb.rdIdx];
endmodule

// File: rtl/flash_rd_control.sv
module flash_rd_control
  import flash_rd_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic                 byteDone,
  input  logic [HDR_SLOTS-1:0] hdrEn,
  input  logic                 burstEn,
  input  logic                 holdEn,
  input  logic                 flushReq,
  input  logic                 csOffReq,
  output seqStrobe_t           stb,
  output logic                 csN,
  output logic                 respValid,
  output logic                 seqBusy
);
  localparam int TAG_W = ADDR_W - BURST_LOG2;
  localparam logic [SLOT_W-1:0] SLOT_NONE = SLOT_W'(HDR_SLOTS);

  seqState_t state, stNext;
  logic [SLOT_W-1:0]     hIdx, hIdxNext;
  logic [BURST_LOG2-1:0] dIdx, dIdxNext, reqOff, lastIdx;
  logic [TAG_W-1:0]      reqTag, blkTag;
  logic                  bufValid, csHold;
  logic                  invalidate, dropHold, finish;

  logic [TAG_W-1:0]      tagIn;
  logic [BURST_LOG2-1:0] offIn;
  logic                  isHit, isSeq;
  logic [SLOT_W-1:0]     firstSlot, afterSlot;

  function automatic logic [SLOT_W-1:0] nextEn(input logic [HDR_SLOTS-1:0] en,
                                               input logic [SLOT_W-1:0] from);
    logic [SLOT_W-1:0] r;
    r = SLOT_NONE;
    for (int i = HDR_SLOTS - 1; i >= 0; i--)
      if (en[i] && (i >= int'(from))) r = SLOT_W'(i);
    return r;
  endfunction

  assign tagIn     = reqAddr[ADDR_W-1:BURST_LOG2];
  assign offIn     = reqAddr[BURST_LOG2-1:0];
  assign isHit     = bufValid && burstEn && (tagIn == blkTag);
  assign isSeq     = burstEn && csHold && (tagIn == blkTag + TAG_W'(1));
  assign firstSlot = nextEn(hdrEn, '0);
  assign afterSlot = nextEn(hdrEn, hIdx + SLOT_W'(1));
  assign lastIdx   = burstEn ? BURST_LOG2'(BURST_BYTES - 1) : '0;

  always_comb begin
    stb        = '0;
    stb.rdIdx  = reqOff;
    stNext     = state;
    hIdxNext   = hIdx;
    dIdxNext   = dIdx;
    invalidate = 1'b0;
    dropHold   = 1'b0;
    finish     = 1'b0;
    respValid  = 1'b0;
    unique case (state)
      S_IDLE: if (reqValid) begin
        if (isHit) begin
          stNext = S_RESP;
        end else if (isSeq) begin
          invalidate   = 1'b1;
          stb.load     = 1'b1;
          stb.loadData = 1'b1;
          dIdxNext     = '0;
          stNext       = S_DATA;
        end else if (csHold) begin
          invalidate = 1'b1;
          dropHold   = 1'b1;
          stNext     = S_GAP;
        end else begin
          invalidate = 1'b1;
          stb.load   = 1'b1;
          if (firstSlot != SLOT_NONE) begin
            stb.hdrSel = firstSlot;
            hIdxNext   = firstSlot;
            stNext     = S_HDR;
          end else begin
            stb.loadData = 1'b1;
            dIdxNext     = '0;
            stNext       = S_DATA;
          end
        end
      end
      S_GAP: begin
        stb.load = 1'b1;
        if (firstSlot != SLOT_NONE) begin
          stb.hdrSel = firstSlot;
          hIdxNext   = firstSlot;
          stNext     = S_HDR;
        end else begin
          stb.loadData = 1'b1;
          dIdxNext     = '0;
          stNext       = S_DATA;
        end
      end
      S_HDR: if (byteDone) begin
        stb.load = 1'b1;
        if (afterSlot != SLOT_NONE) begin
          stb.hdrSel = afterSlot;
          hIdxNext   = afterSlot;
        end else begin
          stb.loadData = 1'b1;
          dIdxNext     = '0;
          stNext       = S_DATA;
        end
      end
      S_DATA: if (byteDone) begin
        stb.capture = 1'b1;
        stb.bufIdx  = burstEn ? dIdx : reqOff;
        if (dIdx == lastIdx) begin
          finish = 1'b1;
          stNext = S_RESP;
        end else begin
          stb.load     = 1'b1;
          stb.loadData = 1'b1;
          dIdxNext     = dIdx + BURST_LOG2'(1);
        end
      end
      S_RESP: begin
        respValid = 1'b1;
        stNext    = S_IDLE;
      end
      default: stNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      hIdx     <= '0;
      dIdx     <= '0;
      reqTag   <= '0;
      reqOff   <= '0;
      blkTag   <= '0;
      bufValid <= 1'b0;
      csHold   <= 1'b0;
    end else begin
      state <= stNext;
      hIdx  <= hIdxNext;
      dIdx  <= dIdxNext;
      if (state == S_IDLE && reqValid) begin
        reqTag <= tagIn;
        reqOff <= offIn;
      end
      if (flushReq || invalidate) bufValid <= 1'b0;
      else if (finish)            bufValid <= burstEn;
      if (finish) blkTag <= reqTag;
      if (csOffReq || dropHold) csHold <= 1'b0;
      else if (finish)          csHold <= burstEn && holdEn;
    end
  end

  assign csN     = !((state == S_HDR) || (state == S_DATA) || csHold);
  assign seqBusy = (state != S_IDLE);
endmodule

// File: rtl/flash_read_seq.sv
module flash_read_seq
  import flash_rd_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [31:0]       regWrData,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              respValid,
  output logic [7:0]        respData,
  output logic              sck,
  output logic              csN,
  output logic              mosi,
  input  logic              miso
);
  seqStrobe_t           stb;
  logic                 byteDone, burstEn, holdEn, flushReq, csOffReq, seqBusy;
  logic [HDR_SLOTS-1:0] hdrEn;

  flash_rd_datapath u_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .miso(miso), .stb(stb), .sck(sck), .mosi(mosi),
    .byteDone(byteDone), .hdrEn(hdrEn), .burstEn(burstEn), .holdEn(holdEn),
    .flushReq(flushReq), .csOffReq(csOffReq), .respData(respData)
  );

  flash_rd_control #(.ADDR_W(ADDR_W)) u_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .byteDone(byteDone), .hdrEn(hdrEn), .burstEn(burstEn), .holdEn(holdEn),
    .flushReq(flushReq), .csOffReq(csOffReq), .stb(stb), .csN(csN),
    .respValid(respValid), .seqBusy(seqBusy)
  );
endmodule

// File: rtl/flash_read_seq_chk.sv
module flash_read_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       sck,
  input logic       csN,
  input logic       mosi,
  input logic       respValid,
  input logic       reqValid,
  input logic       regWrEn,
  input logic [1:0] regAddr,
  input logic       csOffBit,
  input logic       seqBusy
);
  a_r10_sck_needs_cs: assert property (@(posedge clk) disable iff (!rstN)
    sck |-> !csN);

  a_r10_sck_pulse: assert property (@(posedge clk) disable iff (!rstN)
    sck |=> !sck);

  a_r3_mosi_needs_cs: assert property (@(posedge clk) disable iff (!rstN)
    mosi |-> !csN);

  a_r11_resp_pulse: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> !respValid);

  a_r8_cs_off: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 2'd0 && csOffBit && !seqBusy && !reqValid) |=> csN);
endmodule

bind flash_read_seq flash_read_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .sck(sck), .csN(csN), .mosi(mosi),
  .respValid(respValid), .reqValid(reqValid), .regWrEn(regWrEn),
  .regAddr(regAddr), .csOffBit(regWrData[24]), .seqBusy(seqBusy)
);

// File: tb/tb_flash_read_seq.sv
module tb_flash_read_seq;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [1:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic reqValid = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic respValid, sck, csN, mosi;
  logic [7:0] respData;
  logic miso = 1'b0;

  always #2 clk = ~clk;

  flash_read_seq #(.ADDR_W(AW)) dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .reqValid(reqValid), .reqAddr(reqAddr),
    .respValid(respValid), .respData(respData), .sck(sck), .csN(csN),
    .mosi(mosi), .miso(miso)
  );

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  // ---------------- flash model ----------------
  int bitCnt = 0;
  int csFalls = 0;
  int hdrBits = 0;
  int mosiViol = 0;
  int sckViol = 0;
  int csHighRun = 0;
  int lastGap = 0;
  logic [7:0] capHdr [6];

  function automatic logic [7:0] dval(int s, int n);
    return 8'((n * 29 + s * 83 + 17) & 255);
  endfunction

  function automatic logic streamBit(int c);
    int n;
    logic [7:0] b;
    if (c < hdrBits) return 1'b0;
    n = c - hdrBits;
    b = dval(csFalls, n >> 3);
    return b[7 - (n & 7)];
  endfunction

  always @(negedge csN) begin
    bitCnt = 0;
    csFalls++;
    #1 miso = streamBit(0);
  end

  always @(posedge sck) begin
    if (bitCnt < hdrBits) capHdr[bitCnt >> 3] = {capHdr[bitCnt >> 3][6:0], mosi};
    else if (mosi) mosiViol++;
    bitCnt++;
  end

  always @(negedge sck) begin
    #1 miso = streamBit(bitCnt);
  end

  always @(negedge clk) begin
    if (rstN) begin
      if (sck && csN) sckViol++;
      if (csN) csHighRun++;
      else if (csHighRun > 0) begin
        lastGap = csHighRun;
        csHighRun = 0;
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wrReg(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic doRead(logic [AW-1:0] a, output logic [7:0] d, output int lat);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a;
    @(negedge clk);
    reqValid = 1'b0;
    lat = 0;
    while (!respValid && lat < 4000) begin
      @(negedge clk);
      lat++;
    end
    d = respData;
    @(negedge clk);
    chk("R11 response pulse", {31'd0, respValid}, 32'd0);
  endtask

  function automatic logic [31:0] enWord(logic [5:0] e);
    return {16'd0, 1'b0, e[0], 1'b0, e[1], 4'd0, e[2], e[3], e[4], e[5], 4'd0};
  endfunction

  localparam logic [31:0] C_BURST = 32'h0000_0100;
  localparam logic [31:0] C_FLUSH = 32'h0000_0200;
  localparam logic [31:0] C_HOLD  = 32'h0000_0001;
  localparam logic [31:0] C_CSOFF = 32'h0100_0000;

  logic [7:0] slotVal [6];

  task automatic setHeader(logic [5:0] e, logic [7:0] seedByte);
    slotVal[0] = seedByte ^ 8'h5A;
    slotVal[1] = seedByte + 8'h33;
    slotVal[2] = 8'hC3 ^ seedByte;
    slotVal[3] = ~seedByte;
    slotVal[4] = 8'h81 + seedByte;
    slotVal[5] = {seedByte[3:0], seedByte[7:4]};
    wrReg(2'd1, {8'd0, slotVal[0], 8'd0, slotVal[1]});
    wrReg(2'd2, {slotVal[2], slotVal[3], slotVal[4], slotVal[5]});
    wrReg(2'd3, enWord(e));
    hdrBits = 8 * $countones(e);
  endtask

  task automatic chkHeader(string req, logic [5:0] e);
    int j;
    j = 0;
    for (int s = 0; s < 6; s++) begin
      if (e[s]) begin
        chk(req, {24'd0, capHdr[j]}, {24'd0, slotVal[s]});
        j++;
      end
    end
  endtask

  // ---------------- stimulus ----------------
  initial begin
    logic [7:0] d;
    int lat, f0;
    logic [AW-1:0] a;
    for (int i = 0; i < 6; i++) capHdr[i] = '0;
    #1;
    chk("R1 csN at reset", {31'd0, csN}, 32'd1);
    chk("R1 sck at reset", {31'd0, sck}, 32'd0);
    chk("R1 mosi at reset", {31'd0, mosi}, 32'd0);
    chk("R1 respValid at reset", {31'd0, respValid}, 32'd0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // sweep every header enable pattern (R2, R3, R4)
    for (int e = 0; e < 64; e++) begin
      setHeader(6'(e), 8'(e * 7 + 1));
      wrReg(2'd0, C_BURST | C_FLUSH);
      a = AW'(e * 8 + (e % 8));
      f0 = csFalls;
      doRead(a, d, lat);
      chk("R3 fresh access", csFalls, f0 + 1);
      chk("R3 burst data", {24'd0, d}, {24'd0, dval(csFalls, e % 8)});
      chkHeader("R2 header order", 6'(e));
      chk("R3 csN released", {31'd0, csN}, 32'd1);
      doRead(a ^ AW'(5), d, lat);
      chk("R4 hit latency", lat, 0);
      chk("R4 hit data", {24'd0, d}, {24'd0, dval(csFalls, (e % 8) ^ 5)});
      chk("R4 no cs activity", csFalls, f0 + 1);
    end

    // held chip select and sequential continuation (R6, R7)
    setHeader(6'h3F, 8'h9D);
    wrReg(2'd0, C_BURST | C_HOLD | C_FLUSH);
    f0 = csFalls;
    doRead(AW'('h100), d, lat);
    chk("R6 first fresh", csFalls, f0 + 1);
    chk("R6 first data", {24'd0, d}, {24'd0, dval(csFalls, 0)});
    chkHeader("R2 header held", 6'h3F);
    chk("R6 csN held low", {31'd0, csN}, 32'd0);
    doRead(AW'('h10B), d, lat);
    chk("R6 no new select", csFalls, f0 + 1);
    chk("R6 continued data", {24'd0, d}, {24'd0, dval(csFalls, 8 + 3)});
    doRead(AW'('h10D), d, lat);
    chk("R4 hit after continuation", {24'd0, d}, {24'd0, dval(csFalls, 13)});
    chk("R4 hit latency held", lat, 0);
    doRead(AW'('h150), d, lat);
    chk("R7 reselect", csFalls, f0 + 2);
    chk("R7 gap one cycle", lastGap, 1);
    chk("R7 fresh data", {24'd0, d}, {24'd0, dval(csFalls, 0)});
    chkHeader("R7 fresh header", 6'h3F);

    // forced release (R8)
    wrReg(2'd0, C_BURST | C_HOLD | C_CSOFF);
    chk("R8 csN after release", {31'd0, csN}, 32'd1);
    f0 = csFalls;
    doRead(AW'('h158), d, lat);
    chk("R8 fresh after release", csFalls, f0 + 1);
    chk("R8 data after release", {24'd0, d}, {24'd0, dval(csFalls, 0)});

    // flush (R5)
    wrReg(2'd0, C_BURST | C_CSOFF);
    doRead(AW'('h200), d, lat);
    f0 = csFalls;
    doRead(AW'('h201), d, lat);
    chk("R5 hit before flush", csFalls, f0);
    chk("R5 hit data", {24'd0, d}, {24'd0, dval(csFalls, 1)});
    wrReg(2'd0, C_BURST | C_FLUSH);
    doRead(AW'('h201), d, lat);
    chk("R5 fresh after flush", csFalls, f0 + 1);
    chk("R5 data after flush", {24'd0, d}, {24'd0, dval(csFalls, 1)});

    // single-byte mode (R9)
    setHeader(6'h05, 8'h44);
    wrReg(2'd0, C_HOLD);
    f0 = csFalls;
    doRead(AW'('h305), d, lat);
    chk("R9 fresh", csFalls, f0 + 1);
    chk("R9 single byte data", {24'd0, d}, {24'd0, dval(csFalls, 0)});
    chkHeader("R9 header", 6'h05);
    chk("R9 csN released", {31'd0, csN}, 32'd1);
    doRead(AW'('h305), d, lat);
    chk("R9 no buffering", csFalls, f0 + 2);
    chk("R9 repeat data", {24'd0, d}, {24'd0, dval(csFalls, 0)});

    chk("R10 sck only with cs", sckViol, 0);
    chk("R3 mosi low in data", mosiViol, 0);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      vectors++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule